// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block drives the transceiver direction pin of a UART that talks on a half-duplex RS-485 bus. It watches the transmit queue write strobe and the shifter's status: the queue-empty flag, the end-of-stop-bit pulse and the shifter idle flag. It turns the driver on as soon as a character is queued. After the final stop bit of the last queued character has left the line, it keeps the driver on for a programmable number of bit periods, and then releases the bus.

A small write-only register interface holds three settings. An enable bit switches automatic direction control on and off. A polarity bit selects which level of the pin means "driving". An 8-bit turnaround value gives the number of bit periods to wait before release. The turnaround is counted on a single-cycle bit-tick strobe from the baud generator. The direction pin is a registered output.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: With enable set, a transmit queue write while idle makes the direction output active at the next clock edge.
- R2: Control register bit 5 selects polarity. When it is 0, the active level is 0 and the inactive level is 1. When it is 1, the active level is 1 and the inactive level is 0. A polarity change shows on the output from the second edge after the write.
- R3: The output stays active until a cycle in which stop_done, fifo_empty and shifter_idle are all 1. A stop_done with the queue non-empty, or with the shifter busy, does not start the release.
- R4: With a turnaround value N from 1 to 255, the output goes inactive at the edge of the N-th bit_tick that follows the qualifying final stop bit.
- R5: With a turnaround value of 0, the output goes inactive at the edge that samples the qualifying final stop bit.
- R6: A queue write during the turnaround cancels it, and the output stays active. A later release counts the full turnaround again from zero.
- R7: The turnaround advances only on cycles where bit_tick is 1. Clock cycles without a tick do not count toward it.
- R8: With enable clear, the output sits at the inactive level for the current polarity, and queue writes are ignored. Clearing enable while active releases the output at the second edge after the write.
- R9: Reset clears enable, polarity and turnaround to 0 and sets the output to 1.
- R10: Register address 0 is control: bit 0 is enable and bit 5 is polarity, and the other bits have no effect. Register address 1 holds the full 8-bit turnaround value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 control, 1 turnaround |
| cfg_wdata | input | 8 | Register write data |
| fifo_wr | input | 1 | Transmit queue write strobe |
| fifo_empty | input | 1 | Transmit queue is empty |
| stop_done | input | 1 | Pulse: a stop bit has finished on the line |
| shifter_idle | input | 1 | Transmit shifter holds no character |
| bit_tick | input | 1 | Single-cycle pulse, one per bit period |
| dir_out | output | 1 | Registered transceiver direction output |

## Verification
Properties check several rules on every cycle:
- A queue write moves the sequencer to driving (R1), and a write during turnaround cancels it (R6).
- The sequencer stays driving until a qualifying final stop (R3).
- A zero turnaround releases at once (R5).
- The turnaround count holds on cycles without a tick (R7).
- The output sits at the inactive level while disabled (R8).
- The reset state is correct (R9).

Only the bench scenarios can show the full turnaround lengths, up to 255 ticks. The same holds for the restart of the count after a cancel, the one-cycle lag of a polarity change, and the way control bits other than enable and polarity are ignored. Those scenarios run against a cycle model that the bench steps alongside the design.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE  = 2'd0,
    DIR_DRIVE = 2'd1,
    DIR_TURN  = 2'd2
  } dir_state_e;

  localparam int CFG_ADDR_W   = 1;
  localparam int CFG_DATA_W   = 8;
  localparam int TURN_W       = 8;
  localparam logic [CFG_ADDR_W-1:0] ADDR_CTRL = 1'b0;
  localparam logic [CFG_ADDR_W-1:0] ADDR_TURN = 1'b1;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_INV_BIT = 5;

endpackage

// File: rtl/rs485_cfg_regs.sv
module rs485_cfg_regs
  import rs485_dir_pkg::*;
#(
  parameter int ADDR_W = CFG_ADDR_W,
  parameter int DATA_W = CFG_DATA_W,
  parameter int DLY_W  = TURN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic              inv_q,
  output logic [DLY_W-1:0]  dly_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      inv_q <= 1'b0;
      dly_q <= '0;
    end else if (wr) begin
      if (addr == ADDR_CTRL) begin
        en_q  <= wdata[CTRL_EN_BIT];
        inv_q <= wdata[CTRL_INV_BIT];
      end else if (addr == ADDR_TURN) begin
        dly_q <= wdata[DLY_W-1:0];
      end
    end
  end

  // R10
  turn_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADDR_TURN) |=> (dly_q == $past(wdata[DLY_W-1:0])));

endmodule

// File: rtl/rs485_turn_timer.sv
module rs485_turn_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [DLY_W-1:0] limit,
  output logic             expire
);

  localparam int EXT_W = DLY_W + 1;

  logic [DLY_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  assign expire  = run && tick && (cnt_inc == {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_inc[DLY_W-1:0];
    end
  end

  // R7
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       fifo_wr,
  input  logic       fifo_empty,
  input  logic       stop_done,
  input  logic       shifter_idle,
  input  logic       dly_zero,
  input  logic       expire,
  output dir_state_e state_q,
  output dir_state_e state_nxt,
  output logic       run_timer
);

  logic last_stop;

  assign last_stop = stop_done && fifo_empty && shifter_idle;
  assign run_timer = (state_q == DIR_TURN);

  always_comb begin
    state_nxt = state_q;
    if (!en) begin
      state_nxt = DIR_IDLE;
    end else if (fifo_wr) begin
      state_nxt = DIR_DRIVE;
    end else begin
      case (state_q)
        DIR_DRIVE: if (last_stop) state_nxt = dly_zero ? DIR_IDLE : DIR_TURN;
        DIR_TURN:  if (expire) state_nxt = DIR_IDLE;
        default:   state_nxt = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= DIR_IDLE;
    else     state_q <= state_nxt;
  end

  // R1
  start_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_IDLE && en && fifo_wr) |=> (state_q == DIR_DRIVE));

  // R6
  cancel_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_TURN && en && fifo_wr) |=> (state_q == DIR_DRIVE));

  // R3
  hold_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_DRIVE && en && !(stop_done && fifo_empty && shifter_idle))
      |=> (state_q == DIR_DRIVE));

  // R5
  zero_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_DRIVE && en && !fifo_wr && stop_done && fifo_empty &&
     shifter_idle && dly_zero) |=> (state_q == DIR_IDLE));

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int ADDR_W = CFG_ADDR_W,
  parameter int DATA_W = CFG_DATA_W,
  parameter int DLY_W  = TURN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              fifo_wr,
  input  logic              fifo_empty,
  input  logic              stop_done,
  input  logic              shifter_idle,
  input  logic              bit_tick,
  output logic              dir_out
);

  logic             en_q;
  logic             inv_q;
  logic [DLY_W-1:0] dly_q;
  logic             expire;
  logic             run_timer;
  dir_state_e       state_q;
  dir_state_e       state_nxt;

  rs485_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W)) regs_i (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .en_q  (en_q),
    .inv_q (inv_q),
    .dly_q (dly_q)
  );

  rs485_dir_fsm fsm_i (
    .clk          (clk),
    .rst          (rst),
    .en           (en_q),
    .fifo_wr      (fifo_wr),
    .fifo_empty   (fifo_empty),
    .stop_done    (stop_done),
    .shifter_idle (shifter_idle),
    .dly_zero     (dly_q == '0),
    .expire       (expire),
    .state_q      (state_q),
    .state_nxt    (state_nxt),
    .run_timer    (run_timer)
  );

  rs485_turn_timer #(.DLY_W(DLY_W)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .run    (run_timer),
    .tick   (bit_tick),
    .limit  (dly_q),
    .expire (expire)
  );

  // Active level is 0 unless the polarity bit is set.
  always_ff @(posedge clk) begin
    if (rst) dir_out <= 1'b1;
    else     dir_out <= ~((state_nxt != DIR_IDLE) ^ inv_q);
  end

  // R8
  disabled_level_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (dir_out == ~$past(inv_q)));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dir_out && !en_q && !inv_q && dly_q == '0));

endmodule

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [0:0] cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       fifo_wr = 1'b0;
  logic       fifo_empty = 1'b1;
  logic       stop_done = 1'b0;
  logic       shifter_idle = 1'b1;
  logic       bit_tick = 1'b0;
  logic       dir_out;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;
  string cur_req = "R9";

  // Reference model state.
  bit m_en, m_inv, m_act, m_hold, m_exp;
  int m_dly, m_left;

  always #4 clk = ~clk;

  rs485_dir_ctrl dut_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr       (cfg_wr),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .fifo_wr      (fifo_wr),
    .fifo_empty   (fifo_empty),
    .stop_done    (stop_done),
    .shifter_idle (shifter_idle),
    .bit_tick     (bit_tick),
    .dir_out      (dir_out)
  );

  function automatic bit level_for(bit active, bit inv);
    return inv ? active : !active;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_inv = 0; m_dly = 0; m_act = 0; m_hold = 0; m_left = 0; m_exp = 1;
    end else begin
      if (!m_en) begin
        m_act = 0; m_hold = 0;
      end else if (fifo_wr) begin
        m_act = 1; m_hold = 0;
      end else if (m_act && m_hold) begin
        if (bit_tick) begin
          if (m_left <= 1) begin m_act = 0; m_hold = 0; end
          else m_left = m_left - 1;
        end
      end else if (m_act && stop_done && fifo_empty && shifter_idle) begin
        if (m_dly == 0) m_act = 0;
        else begin m_hold = 1; m_left = m_dly; end
      end
      m_exp = level_for(m_act, m_inv);
      if (cfg_wr) begin
        if (cfg_addr == 1'b0) begin m_en = cfg_wdata[0]; m_inv = cfg_wdata[5]; end
        else m_dly = int'(cfg_wdata);
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dir_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    if (!rst) chk(cur_req, dir_out, m_exp);
    fifo_wr = 0; stop_done = 0; bit_tick = 0; cfg_wr = 0;
  endtask

  task automatic wr_cfg(logic a, logic [7:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    step();
  endtask

  task automatic final_stop();
    fifo_empty = 1; shifter_idle = 1; stop_done = 1;
    step();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; step(); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(); step();
    rst = 0;
    cur_req = "R9"; step(); chk("R9", dir_out, 1'b1);

    cur_req = "R8"; fifo_wr = 1; step(); chk("R8", dir_out, 1'b1);

    cur_req = "R1"; wr_cfg(1'b0, 8'h01); chk("R1", dir_out, 1'b1);
    fifo_wr = 1; step(); chk("R1", dir_out, 1'b0);

    cur_req = "R3";
    fifo_empty = 0; stop_done = 1; step(); chk("R3", dir_out, 1'b0);
    fifo_empty = 1; shifter_idle = 0; stop_done = 1; step(); chk("R3", dir_out, 1'b0);
    shifter_idle = 1;

    cur_req = "R5"; final_stop(); chk("R5", dir_out, 1'b1);

    cur_req = "R4"; wr_cfg(1'b1, 8'd3);
    fifo_wr = 1; step(); chk("R4", dir_out, 1'b0);
    final_stop(); chk("R4", dir_out, 1'b0);
    cur_req = "R7";
    for (int i = 0; i < 6; i++) begin step(); chk("R7", dir_out, 1'b0); end
    cur_req = "R4";
    ticks(2); chk("R4", dir_out, 1'b0);
    ticks(1); chk("R4", dir_out, 1'b1);

    cur_req = "R6";
    fifo_wr = 1; step();
    final_stop(); ticks(2);
    fifo_wr = 1; step(); chk("R6", dir_out, 1'b0);
    ticks(4); chk("R6", dir_out, 1'b0);
    final_stop(); ticks(2); chk("R6", dir_out, 1'b0);
    ticks(1); chk("R6", dir_out, 1'b1);

    cur_req = "R2";
    wr_cfg(1'b0, 8'h21); chk("R2", dir_out, 1'b1);
    step(); chk("R2", dir_out, 1'b0);
    fifo_wr = 1; step(); chk("R2", dir_out, 1'b1);

    cur_req = "R8";
    wr_cfg(1'b0, 8'h20); chk("R8", dir_out, 1'b1);
    step(); chk("R8", dir_out, 1'b0);
    fifo_wr = 1; step(); chk("R8", dir_out, 1'b0);

    cur_req = "R10";
    wr_cfg(1'b0, 8'hDF); step(); chk("R10", dir_out, 1'b1);
    fifo_wr = 1; step(); chk("R10", dir_out, 1'b0);
    wr_cfg(1'b0, 8'h00); step(); chk("R10", dir_out, 1'b1);
    wr_cfg(1'b0, 8'h01);
    wr_cfg(1'b1, 8'd255);
    fifo_wr = 1; step(); chk("R10", dir_out, 1'b0);
    final_stop(); ticks(254); chk("R10", dir_out, 1'b0);
    ticks(1); chk("R10", dir_out, 1'b1);

    cur_req = "R1/R3/R4/R6 random";
    for (int i = 0; i < 4000; i++) begin
      fifo_wr      = ($urandom % 8) == 0;
      stop_done    = ($urandom % 5) == 0;
      fifo_empty   = ($urandom % 3) != 0;
      shifter_idle = ($urandom % 4) != 0;
      bit_tick     = ($urandom % 3) == 0;
      if (!m_act && ($urandom % 40) == 0) begin
        cfg_wr   = 1;
        cfg_addr = 1'($urandom % 2);
        if (cfg_addr == 1'b1) cfg_wdata = 8'($urandom % 8);
        else cfg_wdata = {2'b00, 1'($urandom % 2), 4'b0000, 1'(($urandom % 5) != 0)};
      end
      step();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule